// File: doc/BRIEF.md
# Grayscale Clock and Blank Sequencer

This block drives the two timing lines of an LED driver whose outputs use a 12-bit pulse-width counter. It divides the system clock by 16 to make a continuous grayscale clock, high for 8 system clocks and low for 8. It counts the grayscale periods. In the last period of each group of 4096 it raises a short blank pulse, so the driver restarts its PWM cycle in step with the clock train.

The sequence runs for as long as `enable` is high and has no further control. Lowering `enable` silences both lines and rewinds the sequence. Raising it again starts a fresh group, exactly as after reset. The running pulse index is brought out so that the position inside the group can be observed.

Top module: `gsBlankSequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `gsclk` and `blank` are 0 and `pulseIdx` is 0.
- R2: With `enable` held high, `gsclk` has a period of 16 system clocks. It is high for 8 and low for 8, and it first rises one cycle after the first enabled clock edge.
- R3: `pulseIdx` counts the grayscale periods that have completed since the sequence started. It advances by one at the edge that ends each 16-clock period.
- R4: `pulseIdx` wraps from 4095 to 0 at the end of the 4096th grayscale period.
- R5: `blank` is high only in the grayscale period whose index is 4095. It is high for exactly 4 system clocks, starting 2 clocks after `gsclk` falls in that period, so it lies wholly inside the low phase.
- R6: The first `blank` rise comes 65531 clock edges after enabling, at the end of the first full group and not at start-up. Later rises follow every 65536 clocks for as long as `enable` stays high.
- R7: When `enable` is sampled low, the next edge forces `gsclk`, `blank` and `pulseIdx` to 0. When `enable` returns, the sequence restarts exactly as it does after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the sequence while high; rewinds it while low |
| gsclk | output | 1 | Registered grayscale clock, system clock divided by 16 |
| blank | output | 1 | Registered blank pulse, once per 4096 grayscale periods |
| pulseIdx | output | 12 | Index of the current grayscale period within the group |

## Verification
The bench compares all three outputs against an arithmetic model on every cycle. It runs through more than two complete 4096-period groups, so that the wrap of the index and the placement of the blank pulse are seen twice. A short enabled burst is cut off by dropping `enable`. This shows whether the rewind clears the phase as well as the index, because a stale phase would shift every later edge. The gaps between blank rises, measured against the enable point, tell a correct group length apart from one that is off by a period or that fires at start-up.

// File: rtl/gsSeqPkg.sv
package gsSeqPkg;

  // Strobes from the phase control to the counting/output datapath
  typedef struct packed {
    logic advance;    // sequence running this cycle
    logic highPhase;  // current phase lies in the high half of gsclk
    logic blankWin;   // current phase lies in the blank window
    logic periodEnd;  // last phase of a grayscale period
  } seqStrobe_t;

endpackage

// File: rtl/gsSeqCtrl.sv
module gsSeqCtrl
  import gsSeqPkg::*;
#(
  parameter int DIV_RATIO    = 16,
  parameter int BLANK_CYCLES = 4,
  parameter int BLANK_OFFSET = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  output seqStrobe_t strb
);

  localparam int PH_W   = $clog2(DIV_RATIO);
  localparam int HALF   = DIV_RATIO / 2;
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(DIV_RATIO - 1);
  localparam logic [PH_W-1:0] PH_HALF   = PH_W'(HALF);
  localparam logic [PH_W-1:0] PH_BSTART = PH_W'(HALF + BLANK_OFFSET);
  localparam logic [PH_W-1:0] PH_BEND   = PH_W'(HALF + BLANK_OFFSET + BLANK_CYCLES);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      phase <= '0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strb.advance   = enable;
    strb.highPhase = (phase < PH_HALF);
    strb.blankWin  = (phase >= PH_BSTART) && (phase < PH_BEND);
    strb.periodEnd = (phase == PH_LAST);
  end

  // R2: phase returns to zero after the last phase of a period
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (enable && phase == PH_LAST) |=> (phase == '0));

  // R2: phase advances by one inside a period
  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    (enable && phase != PH_LAST) |=> (phase == $past(phase) + 1'b1));

  // R7: disabling rewinds the phase
  a_r7_phase_clear: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (phase == '0));

  // R5: the blank window sits entirely in the low phase
  a_r5_window_low: assert property (@(posedge clk) disable iff (rst)
    strb.blankWin |-> !strb.highPhase);

endmodule

// File: rtl/gsSeqData.sv
module gsSeqData
  import gsSeqPkg::*;
#(
  parameter int PULSE_COUNT  = 4096,
  parameter int BLANK_CYCLES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  seqStrobe_t                     strb,
  output logic                           gsclk,
  output logic                           blank,
  output logic [$clog2(PULSE_COUNT)-1:0] pulseIdx
);

  localparam int IDX_W = $clog2(PULSE_COUNT);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PULSE_COUNT - 1);
  localparam int RUN_W = $clog2(BLANK_CYCLES + 2);

  logic lastPulse;
  assign lastPulse = (pulseIdx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst || !strb.advance) begin
      pulseIdx <= '0;
    end else if (strb.periodEnd) begin
      pulseIdx <= lastPulse ? '0 : pulseIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gsclk <= 1'b0;
      blank <= 1'b0;
    end else begin
      gsclk <= strb.advance && strb.highPhase;
      blank <= strb.advance && strb.blankWin && lastPulse;
    end
  end

  // Checker state: length of the current blank run
  logic [RUN_W-1:0] blankRun;
  always_ff @(posedge clk) begin
    if (rst) begin
      blankRun <= '0;
    end else if (blank) begin
      blankRun <= blankRun + 1'b1;
    end else begin
      blankRun <= '0;
    end
  end

  // R4: index wraps to zero after the last period of a group
  a_r4_idx_wrap: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && strb.periodEnd && lastPulse) |=> (pulseIdx == '0));

  // R3: index holds inside a period
  a_r3_idx_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && !strb.periodEnd) |=> $stable(pulseIdx));

  // R5: blank appears only in the last period, while gsclk is low
  a_r5_blank_place: assert property (@(posedge clk) disable iff (rst)
    blank |-> (lastPulse && !gsclk));

  // R5: blank never outlasts its width
  a_r5_blank_max: assert property (@(posedge clk) disable iff (rst)
    blank |-> (blankRun < RUN_W'(BLANK_CYCLES)));

  // R5: an uninterrupted blank is exactly its full width
  a_r5_blank_full: assert property (@(posedge clk) disable iff (rst)
    ($fell(blank) && $past(strb.advance)) |-> (blankRun == RUN_W'(BLANK_CYCLES)));

  // R7: disabling silences both lines
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> (!gsclk && !blank && pulseIdx == '0));

endmodule

// File: rtl/gsBlankSequencer.sv
module gsBlankSequencer
  import gsSeqPkg::*;
#(
  parameter int DIV_RATIO    = 16,
  parameter int PULSE_COUNT  = 4096,
  parameter int BLANK_CYCLES = 4,
  parameter int BLANK_OFFSET = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enable,
  output logic                           gsclk,
  output logic                           blank,
  output logic [$clog2(PULSE_COUNT)-1:0] pulseIdx
);

  seqStrobe_t strb;

  initial begin
    a_r5_fits_low: assert (BLANK_OFFSET + BLANK_CYCLES <= DIV_RATIO / 2)
      else $error("blank window does not fit in the low phase");
  end

  gsSeqCtrl #(
    .DIV_RATIO   (DIV_RATIO),
    .BLANK_CYCLES(BLANK_CYCLES),
    .BLANK_OFFSET(BLANK_OFFSET)
  ) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .enable(enable),
    .strb  (strb)
  );

  gsSeqData #(
    .PULSE_COUNT (PULSE_COUNT),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .gsclk   (gsclk),
    .blank   (blank),
    .pulseIdx(pulseIdx)
  );

endmodule

// File: tb/tb_gsBlankSequencer.sv
`timescale 1ns/1ps
module tb_gsBlankSequencer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic gsclk, blank;
  logic [11:0] pulseIdx;

  int checks = 0;
  int errors = 0;
  int m = 0;            // enabled edges since the sequence started
  int cyc = 0;          // edges since enable last rose
  int lastRise = -1;
  int riseCount = 0;
  logic prevBlank = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gsBlankSequencer dut (
    .clk(clk), .rst(rst), .enable(enable),
    .gsclk(gsclk), .blank(blank), .pulseIdx(pulseIdx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at m=%0d: actual %0d expected %0d", req, m, act, exp);
    end
  endtask

  task automatic compareModel();
    int p, g, b, idx;
    p   = (m - 1) % 16;
    g   = (m > 0 && p < 8) ? 1 : 0;
    b   = (m > 0 && (((m - 1) / 16) % 4096) == 4095 && p >= 10 && p < 14) ? 1 : 0;
    idx = (m / 16) % 4096;
    check("R2 gsclk", gsclk, g);
    check("R5 blank", blank, b);
    check((idx == 0 && m > 0) ? "R4 pulseIdx wrap" : "R3 pulseIdx", pulseIdx, idx);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      m = (enable && !rst) ? m + 1 : 0;
      cyc++;
      @(negedge clk);
      compareModel();
      if (blank && !prevBlank) begin
        // R6: first rise at 65531, later ones 65536 apart
        if (riseCount == 0) check("R6 first blank", cyc, 65531);
        else check("R6 blank spacing", cyc - lastRise, 65536);
        lastRise = cyc;
        riseCount++;
      end
      prevBlank = blank;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 gsclk", gsclk, 0);
    check("R1 blank", blank, 0);
    check("R1 pulseIdx", pulseIdx, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 gsclk after release", gsclk, 0);
    check("R1 pulseIdx after release", pulseIdx, 0);

    // short burst, then R7 disable mid-period
    enable = 1'b1;
    cyc = 0;
    run(1003);
    enable = 1'b0;
    run(5);
    check("R7 gsclk off", gsclk, 0);
    check("R7 blank off", blank, 0);
    check("R7 index cleared", pulseIdx, 0);

    // R7 restart and long run across two groups (R2..R6)
    enable = 1'b1;
    cyc = 0;
    riseCount = 0;
    prevBlank = 1'b0;
    run(2 * 65536 + 100);
    check("R6 blank count", riseCount, 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule